// File: doc/BRIEF.md
# Bit-Oriented Message Detector

This block monitors the serial bit stream of a telecom data link for bit-oriented messages. Such a message is a 16-bit codeword sent again and again. Each codeword carries a 6-bit message code. One bit enters on each clock cycle in which the bit-valid strobe is high. Cycles without the strobe are ignored.

A code counts as received only after the same codeword has arrived a programmable number of times in a row, each repetition directly following the one before it. When that happens, the block copies the code into an output register and raises a sticky detection flag. The flag stays high until software, or a neighbouring block, pulses the clear input.

A code that keeps repeating after it has been detected does not raise the flag again. Detection is re-armed only by a different code or by a break in the stream.

Top module: `bom_detector`

## Requirements
- R1: A codeword is 16 consecutive accepted bits, in this order: eight ones, a zero, six code bits, a zero. The first code bit received is the most significant bit of the 6-bit code.
- R2: Let N be the effective repeat setting. The flag goes high and `codeOut` takes the code on the same rising edge that samples the final bit of the N-th identical codeword, where each codeword directly follows the previous one. With fewer than N such codewords, the flag stays low.
- R3: A repeat setting of 0, or of 11 to 15, behaves exactly like a setting of 10. Settings 1 to 10 are used as given.
- R4: A correctly placed codeword that carries a code different from the previous codeword restarts the repetition count at one.
- R5: If 16 accepted bits follow a codeword without completing a new one, the repetition count returns to zero. The next codeword then counts as the first.
- R6: Once set, the flag stays high until `flagClr` is sampled high. If a detection and a clear fall in the same cycle, the flag ends up high.
- R7: `codeOut` keeps its value until the next detection.
- R8: After a detection, further repetitions of the same code do not set the flag again. Detection is re-armed by a codeword with a different code or by a break as in R5.
- R9: Cycles with `bitValid` low have no effect on detection, on the repetition count or on `codeOut`, whatever value `bitIn` has.
- R10: After reset, the flag is low and `codeOut` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitIn | input | 1 | Serial data-link bit |
| bitValid | input | 1 | High in each cycle where `bitIn` holds a new bit |
| repeatSel | input | 4 | Required number of identical repetitions (0 and values above 10 mean 10) |
| flagClr | input | 1 | Clears the detection flag |
| codeOut | output | 6 | Code of the most recent detection |
| detectFlag | output | 1 | Sticky detection flag |

## Verification
The assertions take `bitValid`, `bitIn` and `flagClr` to be synchronous to `clk` and defined in every cycle after reset is released. They make no assumption about `repeatSel`: the check that the flag holds without a clear, and the bound on the internal repetition count, must hold for any setting, including one that changes in the middle of a run. The bench drives every input on the falling clock edge and keeps the inputs defined throughout. Its only timing dependence on the design is that the bits of consecutive codewords arrive back to back, except where a break or idle cycles are inserted on purpose.

// File: rtl/bom_pkg.sv
package bom_pkg;

  // Default geometry of a bit-oriented message codeword
  localparam int LEAD_ONES_DEF  = 8;
  localparam int CODE_W_DEF     = 6;
  localparam int CNT_W_DEF      = 4;
  localparam int MAX_REPEAT_DEF = 10;

  // Strobes from control to datapath
  typedef struct packed {
    logic runStart;  // begin a new run at count one, remember the code
    logic runStep;   // one more identical repetition
    logic runDrop;   // stream broken: count back to zero
    logic latch;     // detection: capture the code, set the flag
  } bomCtrl_t;

  // Observations from datapath to control
  typedef struct packed {
    logic patMatch;  // accepted bit completes a well-formed codeword
    logic aligned;   // completion lands exactly one word after the last one
    logic sameCode;  // candidate code equals the code of the running run
    logic expired;   // a full word went by without a new codeword
  } bomStat_t;

endpackage

// File: rtl/bom_datapath.sv
module bom_datapath
  import bom_pkg::*;
#(
  parameter int LEAD_ONES  = LEAD_ONES_DEF,
  parameter int CODE_W     = CODE_W_DEF,
  parameter int CNT_W      = CNT_W_DEF,
  parameter int MAX_REPEAT = MAX_REPEAT_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              flagClr,
  input  bomCtrl_t          ctrl,
  output bomStat_t          stat,
  output logic [CNT_W-1:0]  runCount,
  output logic [CODE_W-1:0] codeOut,
  output logic              detectFlag
);

  localparam int WORD_W  = LEAD_ONES + CODE_W + 2;
  localparam int SINCE_W = $clog2(WORD_W);
  localparam logic [SINCE_W-1:0] WIN_LAST = SINCE_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0]   CNT_MAX  = CNT_W'(MAX_REPEAT);

  logic [WORD_W-1:0]  shiftReg;
  logic [WORD_W-1:0]  shiftNext;
  logic [CODE_W-1:0]  candCode;
  logic [CODE_W-1:0]  runCode;
  logic [SINCE_W-1:0] sinceMatch;
  logic               leadOk;
  logic               fmtOk;
  logic               windowEnd;

  // Newest bit enters at the LSB, so the oldest bit sits at the MSB
  assign shiftNext = {shiftReg[WORD_W-2:0], bitIn};
  assign candCode  = shiftNext[CODE_W:1];

  // Leading-ones check, one AND term per lead bit
  logic [LEAD_ONES-1:0] leadVec;
  genvar gi;
  generate
    for (gi = 0; gi < LEAD_ONES; gi++) begin : g_lead
      assign leadVec[gi] = shiftNext[WORD_W-1-gi];
    end
  endgenerate
  assign leadOk = &leadVec;

  assign fmtOk = leadOk & ~shiftNext[CODE_W+1] & ~shiftNext[0];

  assign windowEnd     = (sinceMatch == WIN_LAST);
  assign stat.patMatch = bitValid & fmtOk;
  assign stat.aligned  = windowEnd & (runCount != '0);
  assign stat.sameCode = (candCode == runCode);
  assign stat.expired  = bitValid & windowEnd & ~fmtOk;

  // Serial shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         shiftReg <= '0;
    else if (bitValid) shiftReg <= shiftNext;
  end

  // Bits since the last completed codeword, saturating at one word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceMatch <= '0;
    end else if (bitValid) begin
      if (fmtOk)               sinceMatch <= '0;
      else if (!windowEnd)     sinceMatch <= sinceMatch + SINCE_W'(1);
    end
  end

  // Repetition counter and the code of the running run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
      runCode  <= '0;
    end else if (ctrl.runStart) begin
      runCount <= CNT_W'(1);
      runCode  <= candCode;
    end else if (ctrl.runStep) begin
      if (runCount != CNT_MAX) runCount <= runCount + CNT_W'(1);
    end else if (ctrl.runDrop) begin
      runCount <= '0;
    end
  end

  // Reported code and sticky flag; detection wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut    <= '0;
      detectFlag <= 1'b0;
    end else begin
      if (ctrl.latch) codeOut <= candCode;
      if (ctrl.latch)   detectFlag <= 1'b1;
      else if (flagClr) detectFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/bom_control.sv
module bom_control
  import bom_pkg::*;
#(
  parameter int CNT_W      = CNT_W_DEF,
  parameter int MAX_REPEAT = MAX_REPEAT_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] repeatSel,
  input  bomStat_t         stat,
  input  logic [CNT_W-1:0] runCount,
  output bomCtrl_t         ctrl
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_REPEAT);

  logic [CNT_W-1:0] target;
  logic             armed;

  // Out-of-range settings fall back to the maximum
  always_comb begin
    if (repeatSel == '0 || repeatSel > CNT_MAX) target = CNT_MAX;
    else                                         target = repeatSel;
  end

  always_comb begin
    ctrl = '0;
    if (stat.patMatch && stat.aligned && stat.sameCode) begin
      ctrl.runStep = 1'b1;
      ctrl.latch   = armed && (runCount >= (target - CNT_W'(1)));
    end else if (stat.patMatch) begin
      ctrl.runStart = 1'b1;
      ctrl.latch    = (target == CNT_W'(1));
    end else if (stat.expired) begin
      ctrl.runDrop = 1'b1;
    end
  end

  // Detection disarms until a new run or a break
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            armed <= 1'b1;
    else if (ctrl.latch)                  armed <= 1'b0;
    else if (ctrl.runStart || ctrl.runDrop) armed <= 1'b1;
  end

endmodule

// File: rtl/bom_detector.sv
module bom_detector
  import bom_pkg::*;
#(
  parameter int LEAD_ONES  = LEAD_ONES_DEF,
  parameter int CODE_W     = CODE_W_DEF,
  parameter int CNT_W      = CNT_W_DEF,
  parameter int MAX_REPEAT = MAX_REPEAT_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic [CNT_W-1:0]  repeatSel,
  input  logic              flagClr,
  output logic [CODE_W-1:0] codeOut,
  output logic              detectFlag
);

  bomCtrl_t         ctrlBus;
  bomStat_t         statBus;
  logic [CNT_W-1:0] runCount;

  bom_datapath #(
    .LEAD_ONES (LEAD_ONES),
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .MAX_REPEAT(MAX_REPEAT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .flagClr   (flagClr),
    .ctrl      (ctrlBus),
    .stat      (statBus),
    .runCount  (runCount),
    .codeOut   (codeOut),
    .detectFlag(detectFlag)
  );

  bom_control #(
    .CNT_W     (CNT_W),
    .MAX_REPEAT(MAX_REPEAT)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .repeatSel(repeatSel),
    .stat     (statBus),
    .runCount (runCount),
    .ctrl     (ctrlBus)
  );

endmodule

// File: rtl/bom_detector_chk.sv
module bom_detector_chk
  import bom_pkg::*;
#(
  parameter int CODE_W     = CODE_W_DEF,
  parameter int CNT_W      = CNT_W_DEF,
  parameter int MAX_REPEAT = MAX_REPEAT_DEF
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitValid,
  input logic              flagClr,
  input logic [CODE_W-1:0] codeOut,
  input logic              detectFlag,
  input bomCtrl_t          ctrlBus,
  input logic [CNT_W-1:0]  runCount
);

  // R6: flag holds without a clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    detectFlag && !flagClr |=> detectFlag);

  // R6: clear with no bit accepted drops the flag
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    detectFlag && flagClr && !bitValid |=> !detectFlag);

  // R9: idle cycles neither move the code nor raise the flag
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(codeOut) && !$rose(detectFlag));

  // R7: reported code only moves on a detection strobe
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.latch |=> $stable(codeOut));

  // R2: detection strobe sets the flag
  a_r2_latch_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.latch |=> detectFlag);

  // R3: repetition count never exceeds the ceiling
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= CNT_W'(MAX_REPEAT));

  // One run-update strobe at most per cycle
  a_r4_one_update: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlBus.runStart, ctrlBus.runStep, ctrlBus.runDrop}));

endmodule

bind bom_detector bom_detector_chk #(
  .CODE_W    (CODE_W),
  .CNT_W     (CNT_W),
  .MAX_REPEAT(MAX_REPEAT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .flagClr   (flagClr),
  .codeOut   (codeOut),
  .detectFlag(detectFlag),
  .ctrlBus   (ctrlBus),
  .runCount  (runCount)
);

// File: tb/bom_detector_bench.sv
module bom_detector_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic       bitValid = 1'b0;
  logic [3:0] repeatSel = 4'd3;
  logic       flagClr = 1'b0;
  logic [5:0] codeOut;
  logic       detectFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bom_detector u_bom_detector (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .repeatSel (repeatSel),
    .flagClr   (flagClr),
    .codeOut   (codeOut),
    .detectFlag(detectFlag)
  );

  task automatic checkFlag(input logic exp, input string tag);
    testsRun++;
    if (detectFlag !== exp) begin
      testsFailed++;
      $display("FAIL %s flag actual=%0d expected=%0d", tag, detectFlag, exp);
    end
  endtask

  task automatic checkCode(input logic [5:0] exp, input string tag);
    testsRun++;
    if (codeOut !== exp) begin
      testsFailed++;
      $display("FAIL %s code actual=%h expected=%h", tag, codeOut, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic clr);
    bitIn = b; bitValid = 1'b1; flagClr = clr;
    @(negedge clk);
    bitValid = 1'b0; flagClr = 1'b0;
  endtask

  // Codeword: eight ones, zero, code MSB first, zero
  task automatic sendWord(input logic [5:0] code, input logic clrLast);
    logic [15:0] w;
    w = {8'hFF, 1'b0, code, 1'b0};
    for (int i = 15; i >= 0; i--) sendBit(w[i], clrLast && (i == 0));
  endtask

  task automatic sendWordGapped(input logic [5:0] code);
    logic [15:0] w;
    w = {8'hFF, 1'b0, code, 1'b0};
    for (int i = 15; i >= 0; i--) begin
      sendBit(w[i], 1'b0);
      bitIn = ~w[i];
      @(negedge clk);
    end
  endtask

  task automatic breakStream();
    for (int i = 0; i < 16; i++) sendBit(1'b0, 1'b0);
  endtask

  task automatic pulseClear();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic idle(input int n, input logic b);
    bitIn = b;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    checkFlag(1'b0, "R10");
    checkCode(6'h00, "R10");
  endtask

  task automatic t_basic();
    repeatSel = 4'd3;
    sendWord(6'h15, 1'b0);
    sendWord(6'h15, 1'b0);
    checkFlag(1'b0, "R2");
    sendWord(6'h15, 1'b0);
    checkFlag(1'b1, "R2");
    checkCode(6'h15, "R1");
  endtask

  task automatic t_noRetrigger();
    pulseClear();
    checkFlag(1'b0, "R6");
    for (int k = 0; k < 4; k++) sendWord(6'h15, 1'b0);
    checkFlag(1'b0, "R8");
  endtask

  task automatic t_restart();
    sendWord(6'h2A, 1'b0);
    sendWord(6'h2A, 1'b0);
    checkCode(6'h15, "R7");
    sendWord(6'h07, 1'b0);
    checkFlag(1'b0, "R4");
    sendWord(6'h07, 1'b0);
    checkFlag(1'b0, "R4");
    sendWord(6'h07, 1'b0);
    checkFlag(1'b1, "R4");
    checkCode(6'h07, "R4");
  endtask

  task automatic t_sticky();
    idle(20, 1'b1);
    checkFlag(1'b1, "R6");
    pulseClear();
    checkFlag(1'b0, "R6");
  endtask

  task automatic t_break();
    repeatSel = 4'd2;
    breakStream();
    sendWord(6'h33, 1'b0);
    breakStream();
    sendWord(6'h33, 1'b0);
    checkFlag(1'b0, "R5");
    sendWord(6'h33, 1'b0);
    checkFlag(1'b1, "R5");
    checkCode(6'h33, "R5");
    pulseClear();
    sendWord(6'h33, 1'b0);
    checkFlag(1'b0, "R8");
    breakStream();
    sendWord(6'h33, 1'b0);
    sendWord(6'h33, 1'b0);
    checkFlag(1'b1, "R8");
  endtask

  task automatic t_clrCollide();
    repeatSel = 4'd1;
    sendWord(6'h01, 1'b0);
    checkCode(6'h01, "R2");
    sendWord(6'h3E, 1'b1);
    checkFlag(1'b1, "R6");
    checkCode(6'h3E, "R6");
  endtask

  task automatic t_default(input logic [3:0] sel);
    pulseClear();
    breakStream();
    repeatSel = sel;
    for (int k = 0; k < 9; k++) sendWord(6'h0C, 1'b0);
    checkFlag(1'b0, "R3");
    sendWord(6'h0C, 1'b0);
    checkFlag(1'b1, "R3");
    checkCode(6'h0C, "R3");
  endtask

  task automatic t_gate();
    pulseClear();
    breakStream();
    repeatSel = 4'd1;
    idle(40, 1'b1);
    checkFlag(1'b0, "R9");
    checkCode(6'h0C, "R9");
    sendWordGapped(6'h29);
    checkFlag(1'b1, "R9");
    checkCode(6'h29, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_noRetrigger();
    t_restart();
    t_sticky();
    t_break();
    t_clrCollide();
    t_default(4'd0);
    t_default(4'd15);
    t_default(4'd10);
    t_gate();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule